// File: doc/BRIEF.md
# Prioritized Interrupt and Trap Sequencer

This block decides, for one processor core, which pending event is serviced next and where the core must fetch from. Its inputs are up to twenty hardware request lines, a software-interrupt request that carries a 6-bit index, an external trap pin and a trap line driven by a neighbouring core. For each hardware line it holds a pending bit and a 2-bit level field. Each field either disables the line or enables it at one of three priorities. The block also holds the global hardware-interrupt enable and a programmable vector base.

The core raises `intr_ok_i` in a cycle where the instruction it has just completed can be interrupted or trapped. At that clock edge the block chooses the winner and records `pc_i`. An interrupt saves `pc_i` to the interrupt return register and a trap saves it to the trap return register. In the next cycle the block emits a one-cycle strobe and the vector address, which is the base plus a fixed offset for that source. The decoded enable, disable and return instructions arrive as single-cycle pulses. Reset is asynchronous and active low, and it must be released synchronously to `clk`.

Top module: `irq_trap_seq`

## Requirements
- R1: After reset: the global enable is 0, no hardware or trap request is pending, no trap routine is active, the strobe is 0, both return registers are 0, the vector base is 0 and every level field is 00.
- R2: The level field of line k sits at bits [2k+1:2k] of `cfg_lvl_i` and is loaded when `cfg_wr_i` is 1. Value 00 disables the line. A disabled line is never serviced, but its pending bit stays set.
- R3: A 0-to-1 change on `irq_i[k]` between two clock edges sets `pend_o[k]` at the second edge. A line held high sets it only once. The bit is cleared at the edge where line k is serviced. If a new rising change and the service of the same line fall on the same edge, the bit stays set.
- R4: `di_i` clears the global enable. Otherwise, servicing a hardware or software interrupt clears it. Otherwise, `ei_i` or `iret_i` sets it. Hardware lines are serviced only while it is 1.
- R5: Among eligible hardware lines, level 11 beats 10 and 10 beats 01. Between equal levels, the lowest index wins.
- R6: The class order is trap pin, then core trap, then software interrupt, then hardware interrupt. A software interrupt is serviced even when the global enable is 0.
- R7: A trap ignores the global enable and all level fields. Taking a trap saves `pc_i` into `trap_ret_o`, raises `in_trap_o`, and leaves the global enable and `pend_o` unchanged. Trap-pin and core-trap requests are latched on a rising change.
- R8: While `in_trap_o` is 1, nothing at all is serviced, and requests stay pending. `tret_i` clears `in_trap_o`.
- R9: Service happens only at an edge where `intr_ok_i` is 1. `svc_o` is then high for exactly the following cycle.
- R10: `vector_o` = vector base + offset. The offset is 0 for the trap pin, 1 for the core trap, 4+k for hardware line k and 32+n for software index n. Servicing an interrupt copies `pc_i` into `irq_ret_o`.
- R11: Only one software request is held at a time. A new request that arrives while one is pending and not being serviced is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_i | input | NUM_IRQ | Hardware request lines, rising-change sensitive |
| cfg_wr_i | input | 1 | Load all level fields |
| cfg_lvl_i | input | 2*NUM_IRQ | Level fields, two bits per line |
| vbase_wr_i | input | 1 | Load the vector base |
| vbase_i | input | ADDR_W | New vector base |
| swi_req_i | input | 1 | Software interrupt request pulse |
| swi_idx_i | input | SWI_W | Software interrupt index |
| trap_pin_i | input | 1 | External trap pin |
| trap_core_i | input | 1 | Trap from the neighbouring core |
| ei_i | input | 1 | Enable-interrupts pulse |
| di_i | input | 1 | Disable-interrupts pulse |
| iret_i | input | 1 | Interrupt-return pulse |
| tret_i | input | 1 | Trap-return pulse |
| intr_ok_i | input | 1 | Current instruction is interruptible |
| pc_i | input | PC_W | Program counter to save |
| svc_o | output | 1 | One-cycle service strobe |
| vector_o | output | ADDR_W | Vector address of the last service |
| irq_ret_o | output | PC_W | Interrupt return register |
| trap_ret_o | output | PC_W | Trap return register |
| gie_o | output | 1 | Global hardware-interrupt enable |
| pend_o | output | NUM_IRQ | Hardware pending bits |
| in_trap_o | output | 1 | Trap routine active |

## Verification
The bench raises several lines of equal and different levels at once. A design that breaks ties toward the highest index, or that ignores levels, would fetch from the wrong vector. It holds a disabled line pending with the enable set, where a design that treats 00 as a valid level would service that line. It sends a trap while a hardware request is pending and enabled, then sends a core trap and a software request during the trap routine. A design that nests traps, lets the trap clear the enable or clear pending bits, or orders the classes wrongly would diverge from the model on the first mismatching strobe. It also sends software requests while the enable is off and two back-to-back software requests before service. These catch a design that masks software requests globally or lets the second request overwrite the first.

// File: rtl/its_pkg.sv
package its_pkg;
  localparam int LVL_W         = 2;
  localparam int OFS_TRAP_PIN  = 0;
  localparam int OFS_TRAP_CORE = 1;
  localparam int OFS_HW_BASE   = 4;
  localparam int OFS_SWI_BASE  = 32;

  typedef enum logic [2:0] {
    SRC_NONE,
    SRC_TRAP_PIN,
    SRC_TRAP_CORE,
    SRC_SWI,
    SRC_HW
  } src_e;
endpackage

// File: rtl/its_pend.sv
module its_pend #(
  parameter int N = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] req_q;
  logic [N-1:0] pend_q;
  logic [N-1:0] pend_d;

  for (genvar k = 0; k < N; k++) begin : g_line
    always_comb begin
      pend_d[k] = (pend_q[k] & ~clr_i[k]) | (req_i[k] & ~req_q[k]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        req_q[k]  <= 1'b0;
        pend_q[k] <= 1'b0;
      end else begin
        req_q[k]  <= req_i[k];
        pend_q[k] <= pend_d[k];
      end
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/its_arb.sv
module its_arb #(
  parameter int N     = 20,
  parameter int LVL_W = 2,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]       pend_i,
  input  logic [N*LVL_W-1:0] lvl_i,
  input  logic               allow_i,
  output logic               found_o,
  output logic [IDX_W-1:0]   idx_o
);
  logic [LVL_W-1:0] best_lvl;
  logic [LVL_W-1:0] lv;

  always_comb begin
    best_lvl = '0;
    idx_o    = '0;
    lv       = '0;
    for (int i = 0; i < N; i++) begin
      lv = lvl_i[i*LVL_W +: LVL_W];
      if (allow_i && pend_i[i] && (lv > best_lvl)) begin
        best_lvl = lv;
        idx_o    = IDX_W'(i);
      end
    end
    found_o = (best_lvl != '0);
  end
endmodule

// File: rtl/its_trap.sv
module its_trap (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic core_i,
  input  logic take_pin_i,
  input  logic take_core_i,
  input  logic tret_i,
  output logic pin_pend_o,
  output logic core_pend_o,
  output logic in_trap_o
);
  logic pin_q, core_q;
  logic pin_pend_q, core_pend_q, in_trap_q;
  logic pin_pend_d, core_pend_d, in_trap_d;

  always_comb begin
    pin_pend_d  = (pin_pend_q & ~take_pin_i) | (pin_i & ~pin_q);
    core_pend_d = (core_pend_q & ~take_core_i) | (core_i & ~core_q);
    if (take_pin_i || take_core_i) begin
      in_trap_d = 1'b1;
    end else if (tret_i) begin
      in_trap_d = 1'b0;
    end else begin
      in_trap_d = in_trap_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q       <= 1'b0;
      core_q      <= 1'b0;
      pin_pend_q  <= 1'b0;
      core_pend_q <= 1'b0;
      in_trap_q   <= 1'b0;
    end else begin
      pin_q       <= pin_i;
      core_q      <= core_i;
      pin_pend_q  <= pin_pend_d;
      core_pend_q <= core_pend_d;
      in_trap_q   <= in_trap_d;
    end
  end

  assign pin_pend_o  = pin_pend_q;
  assign core_pend_o = core_pend_q;
  assign in_trap_o   = in_trap_q;
endmodule

// File: rtl/irq_trap_seq.sv
module irq_trap_seq
  import its_pkg::*;
#(
  parameter int NUM_IRQ = 20,
  parameter int ADDR_W  = 16,
  parameter int PC_W    = 16,
  parameter int SWI_W   = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_IRQ-1:0]       irq_i,
  input  logic                     cfg_wr_i,
  input  logic [NUM_IRQ*LVL_W-1:0] cfg_lvl_i,
  input  logic                     vbase_wr_i,
  input  logic [ADDR_W-1:0]        vbase_i,
  input  logic                     swi_req_i,
  input  logic [SWI_W-1:0]         swi_idx_i,
  input  logic                     trap_pin_i,
  input  logic                     trap_core_i,
  input  logic                     ei_i,
  input  logic                     di_i,
  input  logic                     iret_i,
  input  logic                     tret_i,
  input  logic                     intr_ok_i,
  input  logic [PC_W-1:0]          pc_i,
  output logic                     svc_o,
  output logic [ADDR_W-1:0]        vector_o,
  output logic [PC_W-1:0]          irq_ret_o,
  output logic [PC_W-1:0]          trap_ret_o,
  output logic                     gie_o,
  output logic [NUM_IRQ-1:0]       pend_o,
  output logic                     in_trap_o
);
  localparam int IDX_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;

  // architectural state
  logic                     gie_q, gie_d;
  logic [ADDR_W-1:0]        vbase_q;
  logic [NUM_IRQ*LVL_W-1:0] lvl_q;
  logic                     swi_pend_q, swi_pend_d, swi_load;
  logic [SWI_W-1:0]         swi_idx_q;
  logic [PC_W-1:0]          iret_q, tret_q;
  logic                     svc_q;
  logic [ADDR_W-1:0]        vec_q, vec_d;

  // selection
  logic               can_take;
  logic               pin_pend, core_pend, in_trap;
  logic               hw_found;
  logic [IDX_W-1:0]   hw_idx;
  logic [NUM_IRQ-1:0] hw_clr;
  src_e               sel;
  logic               take_irq, take_trap;

  its_pend #(.N(NUM_IRQ)) u_pend (
    .clk    (clk),
    .rst_n  (rst_n),
    .req_i  (irq_i),
    .clr_i  (hw_clr),
    .pend_o (pend_o)
  );

  its_arb #(.N(NUM_IRQ), .LVL_W(LVL_W)) u_arb (
    .pend_i  (pend_o),
    .lvl_i   (lvl_q),
    .allow_i (gie_q),
    .found_o (hw_found),
    .idx_o   (hw_idx)
  );

  its_trap u_trap (
    .clk         (clk),
    .rst_n       (rst_n),
    .pin_i       (trap_pin_i),
    .core_i      (trap_core_i),
    .take_pin_i  (sel == SRC_TRAP_PIN),
    .take_core_i (sel == SRC_TRAP_CORE),
    .tret_i      (tret_i),
    .pin_pend_o  (pin_pend),
    .core_pend_o (core_pend),
    .in_trap_o   (in_trap)
  );

  // winner selection, fixed class order
  always_comb begin
    can_take = intr_ok_i && !in_trap;
    sel      = SRC_NONE;
    if (can_take) begin
      if (pin_pend)        sel = SRC_TRAP_PIN;
      else if (core_pend)  sel = SRC_TRAP_CORE;
      else if (swi_pend_q) sel = SRC_SWI;
      else if (hw_found)   sel = SRC_HW;
    end
    take_irq  = (sel == SRC_SWI) || (sel == SRC_HW);
    take_trap = (sel == SRC_TRAP_PIN) || (sel == SRC_TRAP_CORE);
    hw_clr    = (sel == SRC_HW) ? (NUM_IRQ'(1) << hw_idx) : '0;
  end

  // vector, enable and software-request next state
  always_comb begin
    unique case (sel)
      SRC_TRAP_PIN:  vec_d = vbase_q + ADDR_W'(OFS_TRAP_PIN);
      SRC_TRAP_CORE: vec_d = vbase_q + ADDR_W'(OFS_TRAP_CORE);
      SRC_SWI:       vec_d = vbase_q + ADDR_W'(OFS_SWI_BASE) + ADDR_W'(swi_idx_q);
      SRC_HW:        vec_d = vbase_q + ADDR_W'(OFS_HW_BASE) + ADDR_W'(hw_idx);
      default:       vec_d = vec_q;
    endcase

    if (di_i)                gie_d = 1'b0;
    else if (take_irq)       gie_d = 1'b0;
    else if (ei_i || iret_i) gie_d = 1'b1;
    else                     gie_d = gie_q;

    swi_load   = swi_req_i && (!swi_pend_q || (sel == SRC_SWI));
    swi_pend_d = swi_load || (swi_pend_q && (sel != SRC_SWI));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gie_q      <= 1'b0;
      vbase_q    <= '0;
      lvl_q      <= '0;
      swi_pend_q <= 1'b0;
      swi_idx_q  <= '0;
      iret_q     <= '0;
      tret_q     <= '0;
      svc_q      <= 1'b0;
      vec_q      <= '0;
    end else begin
      gie_q      <= gie_d;
      swi_pend_q <= swi_pend_d;
      svc_q      <= take_irq || take_trap;
      vec_q      <= vec_d;
      if (vbase_wr_i) vbase_q   <= vbase_i;
      if (cfg_wr_i)   lvl_q     <= cfg_lvl_i;
      if (swi_load)   swi_idx_q <= swi_idx_i;
      if (take_irq)   iret_q    <= pc_i;
      if (take_trap)  tret_q    <= pc_i;
    end
  end

  assign svc_o      = svc_q;
  assign vector_o   = vec_q;
  assign irq_ret_o  = iret_q;
  assign trap_ret_o = tret_q;
  assign gie_o      = gie_q;
  assign in_trap_o  = in_trap;
endmodule

// File: rtl/its_chk.sv
module its_chk #(
  parameter int NUM_IRQ = 20
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_IRQ-1:0] irq_i,
  input logic               ei_i,
  input logic               di_i,
  input logic               iret_i,
  input logic               intr_ok_i,
  input logic               svc_o,
  input logic               gie_o,
  input logic [NUM_IRQ-1:0] pend_o,
  input logic               in_trap_o
);
  assert_svc_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    svc_o |-> $past(intr_ok_i));

  assert_no_nest_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_trap_o) |-> !svc_o);

  assert_irq_drops_gie_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_o && !in_trap_o) |-> !gie_o);

  assert_trap_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_trap_o) |-> svc_o);

  assert_trap_keeps_gie_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(in_trap_o) && !$past(di_i) && !$past(ei_i) && !$past(iret_i))
      |-> (gie_o == $past(gie_o)));

  for (genvar k = 0; k < NUM_IRQ; k++) begin : g_rise
    assert_rise_pends_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_i[k] && !$past(irq_i[k])) |=> pend_o[k]);
  end
endmodule

bind irq_trap_seq its_chk #(.NUM_IRQ(NUM_IRQ)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .irq_i     (irq_i),
  .ei_i      (ei_i),
  .di_i      (di_i),
  .iret_i    (iret_i),
  .intr_ok_i (intr_ok_i),
  .svc_o     (svc_o),
  .gie_o     (gie_o),
  .pend_o    (pend_o),
  .in_trap_o (in_trap_o)
);

// File: tb/irq_trap_seq_tb.sv
module irq_trap_seq_tb;
  localparam int N = 20;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [N-1:0]  irq_i;
  logic          cfg_wr_i;
  logic [2*N-1:0] cfg_lvl_i;
  logic          vbase_wr_i;
  logic [15:0]   vbase_i;
  logic          swi_req_i;
  logic [5:0]    swi_idx_i;
  logic          trap_pin_i, trap_core_i;
  logic          ei_i, di_i, iret_i, tret_i, intr_ok_i;
  logic [15:0]   pc_i;
  logic          svc_o, gie_o, in_trap_o;
  logic [15:0]   vector_o, irq_ret_o, trap_ret_o;
  logic [N-1:0]  pend_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  irq_trap_seq u_dut (
    .clk(clk), .rst_n(rst_n), .irq_i(irq_i), .cfg_wr_i(cfg_wr_i),
    .cfg_lvl_i(cfg_lvl_i), .vbase_wr_i(vbase_wr_i), .vbase_i(vbase_i),
    .swi_req_i(swi_req_i), .swi_idx_i(swi_idx_i), .trap_pin_i(trap_pin_i),
    .trap_core_i(trap_core_i), .ei_i(ei_i), .di_i(di_i), .iret_i(iret_i),
    .tret_i(tret_i), .intr_ok_i(intr_ok_i), .pc_i(pc_i), .svc_o(svc_o),
    .vector_o(vector_o), .irq_ret_o(irq_ret_o), .trap_ret_o(trap_ret_o),
    .gie_o(gie_o), .pend_o(pend_o), .in_trap_o(in_trap_o)
  );

  // ---------------- behavioural reference model ----------------
  int          m_lvl [N];
  bit [N-1:0]  m_pend, m_prev;
  bit          m_gie, m_svc, m_intrap, m_swi_p;
  bit          m_tp_prev, m_tp_p, m_tc_prev, m_tc_p;
  int          m_swi_idx;
  bit [15:0]   m_vbase, m_vec, m_pi, m_pt;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_lvl[i]) m_lvl[i] = 0;
      m_pend = '0; m_prev = '0; m_gie = 0; m_svc = 0; m_intrap = 0;
      m_swi_p = 0; m_swi_idx = 0; m_tp_prev = 0; m_tp_p = 0;
      m_tc_prev = 0; m_tc_p = 0; m_vbase = '0; m_vec = '0; m_pi = '0; m_pt = '0;
    end else begin
      int kind;
      int win;
      kind = 0;
      win = -1;
      if (intr_ok_i && !m_intrap) begin
        if (m_tp_p) kind = 1;
        else if (m_tc_p) kind = 2;
        else if (m_swi_p) kind = 3;
        else if (m_gie) begin
          for (int lv = 3; lv >= 1; lv--)
            for (int i = 0; i < N; i++)
              if (win < 0 && m_pend[i] && m_lvl[i] == lv) win = i;
          if (win >= 0) kind = 4;
        end
      end
      m_svc = (kind != 0);
      case (kind)
        1: begin m_vec = m_vbase;              m_pt = pc_i; end
        2: begin m_vec = m_vbase + 16'd1;      m_pt = pc_i; end
        3: begin m_vec = m_vbase + 16'(32 + m_swi_idx); m_pi = pc_i; end
        4: begin m_vec = m_vbase + 16'(4 + win); m_pi = pc_i; end
        default: ;
      endcase
      for (int i = 0; i < N; i++) begin
        if (kind == 4 && i == win) m_pend[i] = 0;
        if (irq_i[i] && !m_prev[i]) m_pend[i] = 1;
      end
      m_prev = irq_i;
      if (kind == 1) m_tp_p = 0;
      if (trap_pin_i && !m_tp_prev) m_tp_p = 1;
      m_tp_prev = trap_pin_i;
      if (kind == 2) m_tc_p = 0;
      if (trap_core_i && !m_tc_prev) m_tc_p = 1;
      m_tc_prev = trap_core_i;
      if (kind == 1 || kind == 2) m_intrap = 1;
      else if (tret_i) m_intrap = 0;
      if (swi_req_i && (!m_swi_p || kind == 3)) begin
        m_swi_p = 1; m_swi_idx = int'(swi_idx_i);
      end else if (kind == 3) m_swi_p = 0;
      if (di_i) m_gie = 0;
      else if (kind == 3 || kind == 4) m_gie = 0;
      else if (ei_i || iret_i) m_gie = 1;
      if (cfg_wr_i) for (int i = 0; i < N; i++) m_lvl[i] = int'(cfg_lvl_i[2*i +: 2]);
      if (vbase_wr_i) m_vbase = vbase_i;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // compare against the model every cycle, away from the edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R9 svc",      32'(svc_o),      32'(m_svc));
      chk("R10 vector",  32'(vector_o),   32'(m_vec));
      chk("R10 irq_ret", 32'(irq_ret_o),  32'(m_pi));
      chk("R7 trap_ret", 32'(trap_ret_o), 32'(m_pt));
      chk("R4 gie",      32'(gie_o),      32'(m_gie));
      chk("R3 pending",  32'(pend_o),     32'(m_pend));
      chk("R8 in_trap",  32'(in_trap_o),  32'(m_intrap));
    end
  end

  task automatic cyc(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 0; irq_i = '0; cfg_wr_i = 0; cfg_lvl_i = '0; vbase_wr_i = 0;
    vbase_i = '0; swi_req_i = 0; swi_idx_i = '0; trap_pin_i = 0;
    trap_core_i = 0; ei_i = 0; di_i = 0; iret_i = 0; tret_i = 0;
    intr_ok_i = 1; pc_i = 16'h0100;
    cyc(3);
    rst_n = 1;
    cyc();
    // R1 reset state
    chk("R1 gie", 32'(gie_o), 0);
    chk("R1 pend", 32'(pend_o), 0);
    chk("R1 svc", 32'(svc_o), 0);
    chk("R1 in_trap", 32'(in_trap_o), 0);

    // configure levels: line0=01, line2=00, line3=10, line5=11, line7=10
    cfg_lvl_i = '0;
    cfg_lvl_i[1:0] = 2'b01; cfg_lvl_i[7:6] = 2'b10;
    cfg_lvl_i[11:10] = 2'b11; cfg_lvl_i[15:14] = 2'b10;
    cfg_wr_i = 1; vbase_i = 16'h1000; vbase_wr_i = 1;
    cyc();
    cfg_wr_i = 0; vbase_wr_i = 0;

    // requests while globally disabled
    irq_i[2] = 1; irq_i[3] = 1; irq_i[7] = 1;
    cyc(3);
    chk("R4 no service while disabled", 32'(svc_o), 0);
    chk("R3 pending set", 32'(pend_o), 32'h8C);

    ei_i = 1; cyc(); ei_i = 0;
    chk("R4 ei sets", 32'(gie_o), 1);
    cyc();
    chk("R5 tie lowest index svc", 32'(svc_o), 1);
    chk("R5 tie lowest index vec", 32'(vector_o), 32'h1007);
    chk("R10 pc saved", 32'(irq_ret_o), 32'h0100);
    chk("R4 service clears gie", 32'(gie_o), 0);
    cyc();
    chk("R9 one-cycle strobe", 32'(svc_o), 0);

    pc_i = 16'h0200; iret_i = 1; cyc(); iret_i = 0;
    cyc();
    chk("R5 second line vec", 32'(vector_o), 32'h100B);
    iret_i = 1; cyc(); iret_i = 0;
    cyc(3);
    chk("R2 disabled never served", 32'(svc_o), 0);
    chk("R2 disabled stays pending", 32'(pend_o[2]), 1);

    // R9 gating by interruptible state, R5 level order
    irq_i[3] = 0; irq_i[7] = 0;
    intr_ok_i = 0; irq_i[5] = 1; irq_i[0] = 1;
    cyc(4);
    chk("R9 gated", 32'(svc_o), 0);
    intr_ok_i = 1; pc_i = 16'h0300;
    cyc();
    chk("R5 highest level", 32'(vector_o), 32'h1009);
    iret_i = 1; cyc(); iret_i = 0; cyc();
    chk("R5 low level after", 32'(vector_o), 32'h1004);

    // R6 software interrupt bypasses global disable
    irq_i[5] = 0; irq_i[0] = 0;
    di_i = 1; cyc(); di_i = 0;
    pc_i = 16'h0400; swi_req_i = 1; swi_idx_i = 6'd9; cyc(); swi_req_i = 0;
    cyc();
    chk("R6 swi served while disabled", 32'(vector_o), 32'h1029);
    chk("R10 swi pc", 32'(irq_ret_o), 32'h0400);

    // R7 trap over enabled pending hardware, R8 no nesting
    ei_i = 1; cyc(); ei_i = 0;
    pc_i = 16'h0500; trap_pin_i = 1; irq_i[5] = 1;
    cyc(2);
    chk("R7 trap vector", 32'(vector_o), 32'h1000);
    chk("R7 trap pc", 32'(trap_ret_o), 32'h0500);
    chk("R7 gie kept", 32'(gie_o), 1);
    chk("R7 pending kept", 32'(pend_o[5]), 1);
    trap_core_i = 1; swi_req_i = 1; swi_idx_i = 6'd2; cyc();
    trap_core_i = 0; swi_req_i = 0; trap_pin_i = 0;
    cyc(3);
    chk("R8 blocked in trap", 32'(svc_o), 0);
    tret_i = 1; cyc(); tret_i = 0;
    chk("R8 tret clears", 32'(in_trap_o), 0);
    cyc();
    chk("R6 core trap next", 32'(vector_o), 32'h1001);
    tret_i = 1; cyc(); tret_i = 0; cyc();
    chk("R6 swi before hw", 32'(vector_o), 32'h1022);
    ei_i = 1; cyc(); ei_i = 0; cyc();
    chk("R6 hw last", 32'(vector_o), 32'h1009);

    // R11 one outstanding software request
    di_i = 1; intr_ok_i = 0; cyc(); di_i = 0;
    swi_req_i = 1; swi_idx_i = 6'd3; cyc();
    swi_idx_i = 6'd4; cyc();
    swi_req_i = 0; intr_ok_i = 1; cyc();
    chk("R11 first request kept", 32'(vector_o), 32'h1023);
    cyc();
    chk("R11 second discarded", 32'(svc_o), 0);
    cyc(3);
    finish_run();
  end
endmodule